// File: doc/BRIEF.md
# Interrupt-to-transfer request router

This block decides, for each of a set of peripheral interrupt sources, which consumer a raised source flag is delivered to. There are three consumers: the CPU interrupt input, a descriptor-driven data-transfer controller (DTC), and a four-channel DMA controller. A source that any DMA channel has picked as its trigger goes to the DMA controller only. A source whose transfer-enable bit is set goes to the DTC. Every other raised source is passed to the CPU. The CPU's view of each source is masked in both of the first two cases.

The block owns the per-source transfer-enable register. Software loads it through a write-enable/data port. The block clears enable bits itself when a DTC transfer ends under an auto-clear condition. The auto-clear condition for a source holds when its disable-select bit is set, or when the transfer counter has reached zero. The block also emits one-cycle strobes that tell each peripheral to clear its source flag. This happens after an auto-cleared DTC transfer or after a DMA transfer on that source. Once an enable bit has been auto-cleared, a source flag that is still high reaches the CPU, so the CPU can handle the end of the block transfer. Priority arbitration among the CPU requests is left to the interrupt controller that follows this block.

Top module: `irq_xfer_router`

## Requirements
- R1: A source selected by any DMA channel whose select-valid bit is 1 never produces a CPU request and never produces a DTC activation, whatever its enable bit is. Channel `c` names its source with the 4-bit field `dmaSel[4c+3:4c]`.
- R2: `dmaAct[c]` is a one-cycle pulse one clock after the level (`dmaSelVld[c]` AND the flag of the selected source) rises from 0 to 1. It stays 0 while that level remains 1.
- R3: `cpuReq[i]` is combinational: it is 1 exactly when `srcFlag[i]` is 1, `teQ[i]` is 0 and no valid DMA channel selects source `i`.
- R4: `dtcAct[i]` is a one-cycle pulse one clock after the level (`srcFlag[i]` AND `teQ[i]` AND not DMA-selected) rises from 0 to 1.
- R5: When `teWrEn` is 1, `teQ` takes `teWrData` at the next clock edge, except for bits cleared by hardware in that same cycle.
- R6: When `dtcEnd[i]` is 1 and (`discSel[i]` OR `cntZero`) is 1, `teQ[i]` is 0 after the next edge. This hardware clear takes precedence over a software write that sets the same bit in the same cycle.
- R7: A `dtcEnd[i]` pulse while both `discSel[i]` and `cntZero` are 0 leaves `teQ[i]` unchanged and produces no `flagClr[i]`.
- R8: `flagClr[i]` is a one-cycle pulse one clock after a cycle in which (`dtcEnd[i]` AND (`discSel[i]` OR `cntZero`)) OR `dmaEnd[i]` holds.
- R9: Once `teQ[i]` has been auto-cleared, a source flag that is still set drives `cpuReq[i]` to 1 again in the cycle after the clear.
- R10: While reset is asserted and right after it, `teQ`, `dtcAct`, `dmaAct` and `flagClr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcFlag | input | 16 | Level interrupt flags, one per source |
| dmaSel | input | 16 | Four 4-bit source numbers, channel c in bits 4c+3:4c |
| dmaSelVld | input | 4 | Per-channel select-valid bits |
| teWrEn | input | 1 | Software write strobe for the enable register |
| teWrData | input | 16 | Software write data for the enable register |
| dtcEnd | input | 16 | Per-source DTC transfer-end pulses |
| dmaEnd | input | 16 | Per-source DMA transfer-end pulses |
| discSel | input | 16 | Per-source disable-select bits |
| cntZero | input | 1 | Transfer counter has reached zero |
| teQ | output | 16 | Current transfer-enable register |
| cpuReq | output | 16 | Masked interrupt requests to the CPU |
| dtcAct | output | 16 | DTC activation pulses |
| dmaAct | output | 4 | DMA channel activation pulses |
| flagClr | output | 16 | Source-flag clear pulses |

## Verification
A wrong enable bit shows up on `cpuReq` in the same cycle, because the mask is combinational. It shows up on `dtcAct` one cycle after the next rising source flag. A missed or late hardware clear leaves `teQ` high one edge after the qualifying `dtcEnd`, and the CPU request stays masked. A broken DMA-select decode shows up in two ways at once: a CPU request is let through for a DMA-owned source, and the activation pulse is missing on the channel. A behavioural per-cycle model in the bench compares every output after every edge, so any of these faults is reported within one or two clocks of the stimulus that exposes it.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int SRC_N = 16;
  localparam int CH_N  = 4;
  localparam int SEL_W = $clog2(SRC_N);

  // strobes from control to datapath
  typedef struct packed {
    logic [SRC_N-1:0] teHwClr;   // hardware clear of enable bits
  } rtStrobe_t;
endpackage

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = SRC_N,
  parameter int NUM_CH  = CH_N,
  localparam int SW     = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcFlag,
  input  logic [NUM_CH*SW-1:0] dmaSel,
  input  logic [NUM_CH-1:0]    dmaSelVld,
  input  logic                 teWrEn,
  input  logic [NUM_SRC-1:0]   teWrData,
  input  rtStrobe_t            strb,
  output logic [NUM_SRC-1:0]   teQ,
  output logic [NUM_SRC-1:0]   cpuReq,
  output logic [NUM_SRC-1:0]   dtcLvl,
  output logic [NUM_CH-1:0]    dmaLvl
);
  logic [NUM_SRC-1:0] dmaMask;
  logic [NUM_SRC-1:0] chHit [NUM_CH];

  // per-channel decode of the selected source
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SW-1:0] selIdx;
    assign selIdx = dmaSel[c*SW +: SW];
    always_comb begin
      chHit[c] = '0;
      if (dmaSelVld[c]) chHit[c][selIdx] = 1'b1;
    end
    assign dmaLvl[c] = dmaSelVld[c] & srcFlag[selIdx];

    AST_DMA_SRC_NO_CPU: assert property (@(posedge clk) disable iff (!rstN)
      dmaSelVld[c] |-> !cpuReq[selIdx]); // R1
  end

  always_comb begin
    dmaMask = '0;
    for (int c = 0; c < NUM_CH; c++) dmaMask |= chHit[c];
  end

  // transfer-enable register: hardware clear wins over software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) teQ <= '0;
    else       teQ <= (teWrEn ? teWrData : teQ) & ~strb.teHwClr;
  end

  assign cpuReq = srcFlag & ~dmaMask & ~teQ;
  assign dtcLvl = srcFlag & ~dmaMask & teQ;

  AST_TE_MASKS_CPU: assert property (@(posedge clk) disable iff (!rstN)
    (teQ & cpuReq) == '0); // R3
  AST_HWCLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.teHwClr) |=> ((teQ & $past(strb.teHwClr)) == '0)); // R6
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (teWrEn && !(|strb.teHwClr)) |=> (teQ == $past(teWrData))); // R5
endmodule

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = SRC_N,
  parameter int NUM_CH  = CH_N
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] dtcEnd,
  input  logic [NUM_SRC-1:0] dmaEnd,
  input  logic [NUM_SRC-1:0] discSel,
  input  logic               cntZero,
  input  logic [NUM_SRC-1:0] dtcLvl,
  input  logic [NUM_CH-1:0]  dmaLvl,
  output rtStrobe_t          strb,
  output logic [NUM_SRC-1:0] dtcAct,
  output logic [NUM_CH-1:0]  dmaAct,
  output logic [NUM_SRC-1:0] flagClr
);
  logic [NUM_SRC-1:0] autoClr;
  logic [NUM_SRC-1:0] dtcPrev;
  logic [NUM_CH-1:0]  dmaPrev;

  assign autoClr      = discSel | {NUM_SRC{cntZero}};
  assign strb.teHwClr = dtcEnd & autoClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dtcPrev <= '0;
      dmaPrev <= '0;
      dtcAct  <= '0;
      dmaAct  <= '0;
      flagClr <= '0;
    end else begin
      dtcPrev <= dtcLvl;
      dmaPrev <= dmaLvl;
      dtcAct  <= dtcLvl & ~dtcPrev;
      dmaAct  <= dmaLvl & ~dmaPrev;
      flagClr <= strb.teHwClr | dmaEnd;
    end
  end

  AST_DTC_ACT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (|dtcAct) |=> ((dtcAct & $past(dtcAct)) == '0)); // R4
  AST_DMA_ACT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (|dmaAct) |=> ((dmaAct & $past(dmaAct)) == '0)); // R2
  AST_DMAEND_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (|dmaEnd) |=> ((flagClr & $past(dmaEnd)) == $past(dmaEnd))); // R8
  AST_NO_SPURIOUS_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (|dtcEnd) |=> ((flagClr & $past(dtcEnd) & ~$past(dmaEnd) & ~$past(autoClr)) == '0)); // R7
endmodule

// File: rtl/irq_xfer_router.sv
module irq_xfer_router
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = SRC_N,
  parameter int NUM_CH  = CH_N,
  localparam int SW     = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcFlag,
  input  logic [NUM_CH*SW-1:0] dmaSel,
  input  logic [NUM_CH-1:0]    dmaSelVld,
  input  logic                 teWrEn,
  input  logic [NUM_SRC-1:0]   teWrData,
  input  logic [NUM_SRC-1:0]   dtcEnd,
  input  logic [NUM_SRC-1:0]   dmaEnd,
  input  logic [NUM_SRC-1:0]   discSel,
  input  logic                 cntZero,
  output logic [NUM_SRC-1:0]   teQ,
  output logic [NUM_SRC-1:0]   cpuReq,
  output logic [NUM_SRC-1:0]   dtcAct,
  output logic [NUM_CH-1:0]    dmaAct,
  output logic [NUM_SRC-1:0]   flagClr
);
  rtStrobe_t          strb;
  logic [NUM_SRC-1:0] dtcLvl;
  logic [NUM_CH-1:0]  dmaLvl;

  irq_route_dp #(.NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH)) dp_i (
    .clk(clk), .rstN(rstN), .srcFlag(srcFlag), .dmaSel(dmaSel),
    .dmaSelVld(dmaSelVld), .teWrEn(teWrEn), .teWrData(teWrData),
    .strb(strb), .teQ(teQ), .cpuReq(cpuReq), .dtcLvl(dtcLvl), .dmaLvl(dmaLvl)
  );

  irq_route_ctl #(.NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH)) ctl_i (
    .clk(clk), .rstN(rstN), .dtcEnd(dtcEnd), .dmaEnd(dmaEnd),
    .discSel(discSel), .cntZero(cntZero), .dtcLvl(dtcLvl), .dmaLvl(dmaLvl),
    .strb(strb), .dtcAct(dtcAct), .dmaAct(dmaAct), .flagClr(flagClr)
  );
endmodule

// File: tb/irq_xfer_router_tb.sv
module irq_xfer_router_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] srcFlag = '0, teWrData = '0, dtcEnd = '0, dmaEnd = '0, discSel = '0;
  logic [15:0] dmaSel = '0;
  logic [3:0]  dmaSelVld = '0;
  logic        teWrEn = 1'b0, cntZero = 1'b0;
  logic [15:0] teQ, cpuReq, dtcAct, flagClr;
  logic [3:0]  dmaAct;

  int total = 0, fails = 0;
  bit modelOn = 0;

  // reference state
  logic [15:0] mTe = '0, mDtcPrev = '0, mDtcAct = '0, mFlagClr = '0;
  logic [3:0]  mDmaPrev = '0, mDmaAct = '0;

  always #10 clk = ~clk;  // 50 MHz

  irq_xfer_router dut_i (
    .clk(clk), .rstN(rstN), .srcFlag(srcFlag), .dmaSel(dmaSel),
    .dmaSelVld(dmaSelVld), .teWrEn(teWrEn), .teWrData(teWrData),
    .dtcEnd(dtcEnd), .dmaEnd(dmaEnd), .discSel(discSel), .cntZero(cntZero),
    .teQ(teQ), .cpuReq(cpuReq), .dtcAct(dtcAct), .dmaAct(dmaAct), .flagClr(flagClr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit dmaOwned(input int s);
    for (int c = 0; c < 4; c++)
      if (dmaSelVld[c] && (int'(dmaSel[c*4 +: 4]) == s)) return 1;
    return 0;
  endfunction

  function automatic logic [15:0] expCpu();
    logic [15:0] r = '0;
    for (int s = 0; s < 16; s++) r[s] = srcFlag[s] && !dmaOwned(s) && !mTe[s];
    return r;
  endfunction

  // reference model update at each edge
  always @(posedge clk) begin
    if (!rstN) begin
      mTe = '0; mDtcPrev = '0; mDtcAct = '0; mFlagClr = '0; mDmaPrev = '0; mDmaAct = '0;
    end else begin
      for (int s = 0; s < 16; s++) begin
        bit lvl, hw;
        lvl = srcFlag[s] && !dmaOwned(s) && mTe[s];
        mDtcAct[s] = lvl && !mDtcPrev[s];
        mDtcPrev[s] = lvl;
        hw = dtcEnd[s] && (discSel[s] || cntZero);
        mFlagClr[s] = hw || dmaEnd[s];
        if (hw) mTe[s] = 1'b0;
        else if (teWrEn) mTe[s] = teWrData[s];
      end
      for (int c = 0; c < 4; c++) begin
        bit lvl;
        lvl = dmaSelVld[c] && srcFlag[dmaSel[c*4 +: 4]];
        mDmaAct[c] = lvl && !mDmaPrev[c];
        mDmaPrev[c] = lvl;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (modelOn && rstN) begin
      chk("R3 cpuReq model", 32'(cpuReq), 32'(expCpu()));
      chk("R6 teQ model", 32'(teQ), 32'(mTe));
      chk("R4 dtcAct model", 32'(dtcAct), 32'(mDtcAct));
      chk("R2 dmaAct model", 32'(dmaAct), 32'(mDmaAct));
      chk("R8 flagClr model", 32'(flagClr), 32'(mFlagClr));
    end
  end

  task automatic drv(); @(posedge clk); #5; endtask
  task automatic afterEdge(); @(posedge clk); #5; dtcEnd = '0; dmaEnd = '0; teWrEn = 0; @(negedge clk); #2; endtask
  task automatic sameCyc(); @(negedge clk); #2; endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #4_000_000;
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 teQ in reset", 32'(teQ), 0);
    chk("R10 dtcAct in reset", 32'(dtcAct), 0);
    chk("R10 flagClr in reset", 32'(flagClr), 0);
    drv(); rstN = 1'b1;
    sameCyc();
    chk("R10 dmaAct after reset", 32'(dmaAct), 0);
    modelOn = 1;

    // R5: software write
    drv(); teWrEn = 1; teWrData = 16'h00F0;
    afterEdge();
    chk("R5 teQ after write", 32'(teQ), 32'h00F0);

    // R3 / R4: enabled source goes to DTC
    drv(); srcFlag = 16'h0010;
    sameCyc();
    chk("R3 cpuReq masked by enable", 32'(cpuReq[4]), 0);
    afterEdge();
    chk("R4 dtcAct pulse", 32'(dtcAct[4]), 1);
    @(negedge clk); #2;
    chk("R4 dtcAct single cycle", 32'(dtcAct[4]), 0);

    // R7: transfer end without auto-clear
    drv(); dtcEnd = 16'h0010;
    afterEdge();
    chk("R7 teQ kept", 32'(teQ[4]), 1);
    chk("R7 no flagClr", 32'(flagClr[4]), 0);

    // R6 / R8 / R9: auto-clear by disable-select beats a software set
    drv(); dtcEnd = 16'h0010; discSel = 16'h0010; teWrEn = 1; teWrData = 16'h00F0;
    afterEdge();
    chk("R6 teQ hw clear wins", 32'(teQ[4]), 0);
    chk("R8 flagClr after dtc end", 32'(flagClr[4]), 1);
    chk("R9 cpuReq unmasked", 32'(cpuReq[4]), 1);
    discSel = '0;

    // R6: counter-zero as auto-clear term
    drv(); dtcEnd = 16'h0020; cntZero = 1;
    afterEdge();
    chk("R6 teQ cleared by counter zero", 32'(teQ[5]), 0);
    cntZero = 0;

    // R1 / R2: DMA-owned source
    drv(); dmaSel = 16'h0700; dmaSelVld = 4'b0100; srcFlag = 16'h0080;
    sameCyc();
    chk("R1 cpuReq masked by DMA", 32'(cpuReq[7]), 0);
    afterEdge();
    chk("R2 dmaAct pulse", 32'(dmaAct), 32'h4);
    chk("R1 no dtcAct for DMA source", 32'(dtcAct[7]), 0);
    @(negedge clk); #2;
    chk("R2 dmaAct single cycle", 32'(dmaAct), 0);

    // R8: DMA transfer end
    drv(); dmaEnd = 16'h0080;
    afterEdge();
    chk("R8 flagClr after dma end", 32'(flagClr[7]), 1);

    // mixed stimulus against the model
    for (int k = 0; k < 3000; k++) begin
      drv();
      srcFlag   = 16'($urandom) & 16'($urandom);
      dmaSel    = 16'($urandom);
      dmaSelVld = 4'($urandom) & 4'($urandom);
      teWrEn    = ($urandom % 6) == 0;
      teWrData  = 16'($urandom);
      dtcEnd    = 16'($urandom) & 16'($urandom) & 16'($urandom);
      dmaEnd    = 16'($urandom) & 16'($urandom) & 16'($urandom);
      discSel   = 16'($urandom);
      cntZero   = ($urandom % 5) == 0;
    end
    drv();
    dtcEnd = '0; dmaEnd = '0; teWrEn = 0;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule